// File: doc/BRIEF.md
# Sequenced Carry-less Polynomial Multiplier

This block multiplies two polynomials over GF(2). Each operand is a 512-bit vector of eight 64-bit words, and the block returns the full 1024-bit product, with no reduction step. It forms the 64 word-by-word cross products over several clock cycles. A small group of 64x64 carry-less cores does this work, and the parameter `LANES` sets how many products are made per cycle.

Each cross product a_i*b_j is 128 bits wide. When i+j is even, the product is XORed into an even-column accumulator at bit offset 64(i+j). Those slots sit on 128-bit boundaries. When i+j is odd, the product goes into a separate odd-column accumulator at offset 64(i+j-1). When the run ends, the odd accumulator is moved up by one word and merged with the even one by XOR.

A half-width mode uses the same datapath. It multiplies the low four words of each operand and gives a 512-bit product in the low half of the result. A caller pulses `start` with the operands and the mode, then waits for the one-cycle `done` pulse.

Top module: `clmul512_sched`

## Requirements
- R1: In full mode (`half_mode`=0), `product` during the `done` cycle equals the carry-less product of `op_a` and `op_b` as sampled at the accepted start: bit k is the XOR of a[i]&b[j] over all i+j=k, for i and j in 0..511.
- R2: A product word pair whose index sum is odd lands at bit offset 64(i+j) of the result. The odd-column sum is realigned by exactly one 64-bit word.
- R3: In half mode (`half_mode`=1), only `op_a[255:0]` and `op_b[255:0]` are used. `product[511:0]` is their carry-less product, `product[1023:512]` is zero, and the upper operand bits have no effect.
- R4: `done` rises exactly 64/LANES + 1 cycles after the clock edge that accepts `start` in full mode, and 16/LANES + 1 cycles after it in half mode. With the default `LANES`=2 that is 33 and 9 cycles.
- R5: `done` is high for exactly one cycle. `busy` is high from the cycle after an accepted start through the `done` cycle.
- R6: While `busy` is high, `start` is ignored. It changes neither the operands, the mode, the result nor the timing of the run in progress.
- R7: While the block is idle after a `done`, `product` holds the last result until the next accepted start.
- R8: After reset, `busy`=0, `done`=0 and `product`=0.
- R9: Both accumulators are cleared when a start is accepted, so a new run shows no trace of the previous result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a multiplication (accepted only when idle) |
| half_mode | input | 1 | 1: four-word operands, 512-bit product |
| op_a | input | 512 | First operand, word i at bits 64i+63:64i |
| op_b | input | 512 | Second operand, same layout |
| busy | output | 1 | A multiplication is in progress |
| done | output | 1 | One-cycle pulse: product valid |
| product | output | 1024 | Carry-less product |

## Verification
All-ones operands in both modes turn on every cross product at once. This exposes any dropped or duplicated word pair, because the XOR pattern of the product depends on how many times each column is hit. Single-bit operands with an odd word-index sum, and others with an even sum, each place one bit. That bit shows at once whether the odd column was realigned by the right distance, and whether the even slots tile correctly. Random operands, half-mode runs with junk in the upper words, a start asserted mid-run and back-to-back runs separate correct arithmetic from stale accumulator contents, from leakage of the upper words, and from a start that was wrongly accepted.

// File: rtl/pm_pkg.sv
package pm_pkg;
  localparam int QW = 64;
  typedef enum logic [1:0] {ST_IDLE, ST_RUN, ST_FIN} pm_state_e;
endpackage

// File: rtl/clmul_core64.sv
module clmul_core64 #(
  parameter int W = 64
) (
  input  logic [W-1:0]   a,
  input  logic [W-1:0]   b,
  output logic [2*W-1:0] p
);
  // Shift-and-XOR carry-less multiply, fully combinational
  always_comb begin
    p = '0;
    for (int i = 0; i < W; i++) begin
      if (b[i]) p = p ^ ({{W{1'b0}}, a} << i);
    end
  end
endmodule

// File: rtl/pm_sched.sv
module pm_sched
  import pm_pkg::*;
#(
  parameter int NQ    = 8,
  parameter int LANES = 2
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        start,
  input  logic                        half_mode,
  output logic                        busy,
  output logic                        done,
  output logic                        acc_en,
  output logic                        clr,
  output logic                        half_q,
  output logic [$clog2(NQ*NQ)-1:0]    base_q
);
  localparam int NPAIR = NQ * NQ;
  localparam int NH    = NQ / 2;
  localparam int KW    = $clog2(NPAIR);
  localparam logic [KW-1:0] LAST_FULL = KW'(NPAIR - LANES);
  localparam logic [KW-1:0] LAST_HALF = KW'(NH * NH - LANES);
  localparam logic [KW-1:0] STEP      = KW'(LANES);

  pm_state_e        state_q, state_d;
  logic [KW-1:0]    base_d;
  logic             half_d;
  logic             last;
  logic             en_state, en_base, en_half;

  assign last = (base_q == (half_q ? LAST_HALF : LAST_FULL));
  assign clr  = (state_q == ST_IDLE) && start;

  // next-state logic
  always_comb begin
    state_d = state_q;
    base_d  = base_q;
    half_d  = half_q;
    case (state_q)
      ST_IDLE: begin
        if (start) begin
          state_d = ST_RUN;
          base_d  = '0;
          half_d  = half_mode;
        end
      end
      ST_RUN: begin
        base_d = base_q + STEP;
        if (last) state_d = ST_FIN;
      end
      ST_FIN:  state_d = ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
  end

  assign en_state = (state_d != state_q);
  assign en_base  = clr || (state_q == ST_RUN);
  assign en_half  = clr;

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      base_q  <= '0;
      half_q  <= 1'b0;
    end else begin
      if (en_state) state_q <= state_d;
      if (en_base)  base_q  <= base_d;
      if (en_half)  half_q  <= half_d;
    end
  end

  assign busy   = (state_q != ST_IDLE);
  assign done   = (state_q == ST_FIN);
  assign acc_en = (state_q == ST_RUN);
endmodule

// File: rtl/pm_accum.sv
module pm_accum
  import pm_pkg::*;
#(
  parameter int NQ    = 8,
  parameter int LANES = 2
) (
  input  logic                                 clk,
  input  logic                                 rst_n,
  input  logic                                 clr,
  input  logic                                 en,
  input  logic [LANES-1:0][2*QW-1:0]           prod,
  input  logic [LANES-1:0][$clog2(2*NQ)-1:0]   wsum,
  output logic [2*NQ*QW-1:0]                   result
);
  localparam int RW = 2 * NQ * QW;

  logic [RW-1:0] even_q, even_d;
  logic [RW-1:0] odd_q,  odd_d;

  // Even sums tile at 64*s (128-bit aligned); odd sums sit one word low
  always_comb begin
    even_d = even_q;
    odd_d  = odd_q;
    for (int l = 0; l < LANES; l++) begin
      if (wsum[l][0])
        odd_d  = odd_d  ^ (RW'(prod[l]) << (QW * (int'(wsum[l]) - 1)));
      else
        even_d = even_d ^ (RW'(prod[l]) << (QW * int'(wsum[l])));
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      even_q <= '0;
      odd_q  <= '0;
    end else if (clr) begin
      even_q <= '0;
      odd_q  <= '0;
    end else if (en) begin
      even_q <= even_d;
      odd_q  <= odd_d;
    end
  end

  // Final merge: realign odd column by one word
  assign result = even_q ^ (odd_q << QW);
endmodule

// File: rtl/clmul512_sched.sv
module clmul512_sched
  import pm_pkg::*;
#(
  parameter int NQ    = 8,
  parameter int LANES = 2
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  start,
  input  logic                  half_mode,
  input  logic [NQ*QW-1:0]      op_a,
  input  logic [NQ*QW-1:0]      op_b,
  output logic                  busy,
  output logic                  done,
  output logic [2*NQ*QW-1:0]    product
);
  localparam int OW   = NQ * QW;
  localparam int KW   = $clog2(NQ * NQ);
  localparam int LOGQ = $clog2(NQ);
  localparam int LOGH = LOGQ - 1;
  localparam int SW   = $clog2(2 * NQ);

  logic                          acc_en, clr, half_q;
  logic [KW-1:0]                 base_q;
  logic [OW-1:0]                 a_q, b_q;
  logic [LANES-1:0][2*QW-1:0]    prod;
  logic [LANES-1:0][SW-1:0]      wsum;

  pm_sched #(.NQ(NQ), .LANES(LANES)) u_sched (
    .clk(clk), .rst_n(rst_n), .start(start), .half_mode(half_mode),
    .busy(busy), .done(done), .acc_en(acc_en), .clr(clr),
    .half_q(half_q), .base_q(base_q)
  );

  // operand capture on accepted start
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      a_q <= '0;
      b_q <= '0;
    end else if (clr) begin
      a_q <= op_a;
      b_q <= op_b;
    end
  end

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    logic [KW-1:0]   k;
    logic [LOGQ-1:0] ii, jj;
    logic [QW-1:0]   wa, wb;

    assign k = base_q + KW'(l);

    // Pair index split depends on mode: 8x8 or 4x4 word grid
    always_comb begin
      if (half_q) begin
        ii = LOGQ'(k[2*LOGH-1:LOGH]);
        jj = LOGQ'(k[LOGH-1:0]);
      end else begin
        ii = k[KW-1:LOGQ];
        jj = k[LOGQ-1:0];
      end
    end

    assign wa = a_q[ii*QW +: QW];
    assign wb = b_q[jj*QW +: QW];
    assign wsum[l] = SW'(ii) + SW'(jj);

    clmul_core64 #(.W(QW)) u_core (.a(wa), .b(wb), .p(prod[l]));
  end

  pm_accum #(.NQ(NQ), .LANES(LANES)) u_acc (
    .clk(clk), .rst_n(rst_n), .clr(clr), .en(acc_en),
    .prod(prod), .wsum(wsum), .result(product)
  );
endmodule

// File: rtl/clmul512_sched_chk.sv
module clmul512_sched_chk #(
  parameter int NQ    = 8,
  parameter int LANES = 2
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 start,
  input logic                 half_mode,
  input logic                 busy,
  input logic                 done,
  input logic [2*NQ*64-1:0]   product
);
  localparam int RW  = 2 * NQ * 64;
  localparam int NF  = NQ * NQ / LANES;
  localparam int NHC = (NQ / 2) * (NQ / 2) / LANES;

  int   cnt;
  logic hq;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= 0;
      hq  <= 1'b0;
    end else if (start && !busy) begin
      cnt <= 1;
      hq  <= half_mode;
    end else if (done) begin
      cnt <= 0;
    end else if (cnt != 0) begin
      cnt <= cnt + 1;
    end
  end

  a_r4_done_latency: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (cnt == (hq ? NHC : NF) + 1));
  a_r5_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  a_r5_busy_after_accept: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy) |=> busy);
  a_r5_done_in_busy: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> busy);
  a_r3_half_upper_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (done && hq) |-> (product[RW-1:RW/2] == '0));
  a_r7_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !$past(busy)) |-> $stable(product));
endmodule

bind clmul512_sched clmul512_sched_chk #(.NQ(NQ), .LANES(LANES)) u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .half_mode(half_mode),
  .busy(busy), .done(done), .product(product)
);

// File: tb/clmul512_sched_tb.sv
module clmul512_sched_tb;
  localparam int LANES = 2;
  localparam int RUN_F = 64 / LANES;
  localparam int RUN_H = 16 / LANES;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          start = 1'b0;
  logic          half_mode = 1'b0;
  logic [511:0]  op_a = '0, op_b = '0;
  logic          busy, done;
  logic [1023:0] product;

  int n_chk = 0, n_fail = 0, cyc = 0;
  string tag = "R1";

  // model state
  bit            m_busy = 0, m_done = 0;
  int            m_left = 0;
  logic [1023:0] m_exp = '0, m_hold = '0;

  always #2 clk = ~clk;

  clmul512_sched #(.NQ(8), .LANES(LANES)) u_dut (
    .clk(clk), .rst_n(rst_n), .start(start), .half_mode(half_mode),
    .op_a(op_a), .op_b(op_b), .busy(busy), .done(done), .product(product)
  );

  function automatic logic [1023:0] ref_mul(input logic [511:0] a, b, input logic h);
    logic [1023:0] r = '0;
    int n = h ? 256 : 512;
    for (int i = 0; i < n; i++)
      if (a[i])
        for (int j = 0; j < n; j++)
          if (b[j]) r[i+j] = ~r[i+j];
    return r;
  endfunction

  task automatic chk(input bit ok, input string req, input logic [1023:0] act, exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s at cycle %0d: actual %h expected %h", req, cyc, act, exp);
    end
  endtask

  // behavioural reference model, advanced on each rising edge
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_busy = 0; m_done = 0; m_left = 0; m_hold = '0;
    end else begin
      cyc++;
      if (m_done) begin
        m_done = 0; m_busy = 0;
      end else if (m_busy) begin
        m_left--;
        if (m_left == 0) begin m_done = 1; m_hold = m_exp; end
      end else if (start) begin
        m_busy = 1;
        m_left = half_mode ? RUN_H : RUN_F;
        m_exp  = ref_mul(op_a, op_b, half_mode);
      end
    end
  end

  // compare on every cycle, away from the active edge
  always @(negedge clk) begin
    if (rst_n) begin
      chk(done === m_done, "R4/R5 done timing (R4)", 1024'(done), 1024'(m_done));
      chk(busy === m_busy, "R5 busy", 1024'(busy), 1024'(m_busy));
      if (m_done) chk(product === m_exp, tag, product, m_exp);
      if (!m_busy) chk(product === m_hold, "R7/R8 idle product hold (R7)", product, m_hold);
    end
  end

  // watchdog
  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  task automatic launch(input logic [511:0] a, b, input logic h, input string t);
    @(negedge clk);
    tag = t; op_a = a; op_b = b; half_mode = h; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic finish_run();
    while (m_busy) @(negedge clk);
  endtask

  function automatic logic [511:0] rnd512();
    logic [511:0] v;
    for (int i = 0; i < 16; i++) v[32*i +: 32] = $urandom;
    return v;
  endfunction

  initial begin
    logic [511:0] ra, rb;
    repeat (3) @(negedge clk);
    // R8: reset state
    chk(busy === 1'b0 && done === 1'b0 && product === '0, "R8 reset state",
        {product[1021:0], busy, done}, '0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    launch({512{1'b1}}, {512{1'b1}}, 1'b0, "R1 all-ones full");
    finish_run();
    repeat (3) @(negedge clk);   // R7 hold observed in idle cycles

    // R2: odd index sum 1+2, bits 5 and 63 -> product bit 64*3+68
    launch(512'(1) << (64*1+5), 512'(1) << (64*2+63), 1'b0, "R2 odd-column bit");
    finish_run();
    chk(product === (1024'(1) << (64*3+68)), "R2 odd bit position", product,
        1024'(1) << (64*3+68));
    // even sum 7+7, top bits -> bit 1022
    launch(512'(1) << 511, 512'(1) << 511, 1'b0, "R2 even-column top bit");
    finish_run();
    launch(512'(1) << (64*4+1), 512'(1) << (64*3), 1'b0, "R2 odd sum 7");
    finish_run();

    // R3: half mode with junk in upper words
    launch({{256{1'b1}}, {256{1'b1}}}, {rnd512()}, 1'b1, "R3 half all-ones low, junk high");
    finish_run();
    chk(product[1023:512] === '0, "R3 half upper zero", product, '0);
    ra = rnd512(); rb = rnd512();
    launch(ra, rb, 1'b1, "R3 half random");
    finish_run();

    for (int t = 0; t < 4; t++) begin
      launch(rnd512(), rnd512(), 1'b0, "R1 random full");
      finish_run();
    end

    // R6: start while busy is ignored
    ra = rnd512(); rb = rnd512();
    launch(ra, rb, 1'b0, "R6 start during busy");
    repeat (5) @(negedge clk);
    op_a = '1; op_b = '1; half_mode = 1'b1; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    finish_run();

    // R9: back-to-back runs, second must not carry the first
    launch({512{1'b1}}, {512{1'b1}}, 1'b0, "R9 first of pair");
    finish_run();
    launch(512'(1), 512'(3), 1'b0, "R9 clean second run");
    finish_run();
    chk(product === 1024'(3), "R9 accumulator cleared", product, 1024'(3));

    repeat (4) @(negedge clk);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule